// File: doc/BRIEF.md
# Cartridge Address Decoder and Control Registers

This block sits on a 32-bit host bus and sorts every address into one of three regions: a 64 MB window for ROM storage, a 2 kB window for save memory, or a pair of 32-bit control registers. Each memory window is reported by a one-cycle select strobe so that a downstream controller can serve the access. The block answers register and error accesses itself, with a registered acknowledge one cycle after the request.

A configuration register holds three enables. One of them picks whether the ROM window reaches SDRAM or a bootloader flash image. Another opens the save-memory window, and the last reports the save-chip size. A host reset or NMI event turns off only the SDRAM enable. The ROM window then falls back to the flash image, and the save settings are kept. A second register carries boot overrides from host software to the bootloader. The block decodes that register into an override-valid flag and an effective video standard.

Top module: `cart_decoder`

## Requirements
- R1: After reset, every configuration bit is 0 and the boot-override word is 0x0000_0000. override_valid is 0, video_eff is 3, and every select strobe, bus_ack and bus_err are low.
- R2: An access to 0x1000_0000..0x13FF_FFFF with addr[0]=0 asserts sdram_sel in the same cycle when configuration bit 1 is 1. When bit 1 is 0 it asserts flash_sel instead.
- R3: An access to 0x1D00_0000..0x1D00_07FF with addr[1:0]=0 asserts save_sel in the same cycle, but only while configuration bit 3 is 1. When bit 3 is 0 the same access is an error.
- R4: An access to 0x1E00_0000 (configuration) or 0x1E00_0004 (boot override) with addr[1:0]=0 asserts reg_sel. bus_ack follows one cycle later. For a read, bus_rdata carries the register value with that ack; for a write, bus_rdata is 0.
- R5: The configuration word reads back bit 4 (save size, 0=4k, 1=16k), bit 3 (save enable) and bit 1 (SDRAM enable). Bits 31:5, 2 and 0 always read 0, and writes to them are ignored.
- R6: A host_evt cycle clears configuration bit 1 and keeps bits 4 and 3. When host_evt coincides with a configuration write, bits 4 and 3 take the written value and bit 1 ends up 0.
- R7: The boot-override register stores and returns all 32 written bits: code in bits 3:0, video standard in bits 5:4 (0=PAL, 1=NTSC, 2=MPAL, 3=no override), pass-through bits in 31:6.
- R8: override_valid is 1 exactly when the boot code is between 1 and 7 inclusive. Codes 0 and 8..15 give 0.
- R9: video_eff equals bits 5:4 of the boot word while override_valid is 1, and equals 3 otherwise.
- R10: A misaligned access or an unmapped address selects no region. It gives bus_ack together with bus_err one cycle later, with bus_rdata = 0. A write made this way changes no register.
- R11: A register write takes effect on the clock edge that accepts it, so the very next access is decoded with the new configuration.
- R12: At most one of sdram_sel, flash_sel, save_sel and reg_sel is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| host_evt | input | 1 | Host reset/NMI event, one cycle per event |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| sdram_sel | output | 1 | ROM window served by SDRAM |
| flash_sel | output | 1 | ROM window served by the boot flash image |
| save_sel | output | 1 | Save-memory window selected |
| reg_sel | output | 1 | Control register selected |
| bus_ack | output | 1 | Register or error access completed |
| bus_err | output | 1 | Completed access was misaligned or unmapped |
| bus_rdata | output | 32 | Register read data, 0 otherwise |
| cfg_sdram_en | output | 1 | Configuration bit 1 |
| cfg_save_serial_en | output | 1 | Configuration bit 3 |
| cfg_save_16k | output | 1 | Configuration bit 4 |
| boot_word | output | 32 | Boot-override register contents |
| override_valid | output | 1 | Boot code is a valid override |
| video_eff | output | 2 | Effective video-standard code |

## Verification
The bench probes the edges of each window. It reads the last halfword of the ROM window and the last word of the save window, then the first byte past each window. A range compare that is off by one would either select past the end or fault inside it. It also issues misaligned register writes followed by read-back, which catches a design that drops the alignment check on the write path. It pulses the host event alone and together with a configuration write, to catch a design that clears the save bits as well or lets the write restore SDRAM mode. A sweep of all sixteen boot codes exposes a wrong bound on the override range, such as one that treats 0 or 8 as valid.

// File: rtl/cart_pkg.sv
package cart_pkg;

  localparam int BUS_W = 32;

  // configuration bit positions (decoded by the memory controllers)
  localparam int CFG_SDRAM_BIT = 1;
  localparam int CFG_SAVE_BIT  = 3;
  localparam int CFG_16K_BIT   = 4;

  // boot-override field layout
  localparam int BOOT_CODE_W   = 4;
  localparam int BOOT_VID_LSB  = 4;
  localparam int BOOT_VID_W    = 2;
  localparam int BOOT_CODE_MIN = 1;
  localparam int BOOT_CODE_MAX = 7;
  localparam logic [BOOT_VID_W-1:0] VID_NONE = '1;

  typedef struct packed {
    logic save_16k;
    logic save_en;
    logic sdram_en;
  } cfg_t;

  function automatic logic boot_code_ok(input logic [BOOT_CODE_W-1:0] code);
    return (int'(code) >= BOOT_CODE_MIN) && (int'(code) <= BOOT_CODE_MAX);
  endfunction

  function automatic logic [BOOT_VID_W-1:0] eff_video(input logic [BUS_W-1:0] word);
    logic [BOOT_VID_W-1:0] vid;
    vid = word[BOOT_VID_LSB +: BOOT_VID_W];
    return boot_code_ok(word[BOOT_CODE_W-1:0]) ? vid : VID_NONE;
  endfunction

  function automatic logic [BUS_W-1:0] cfg_word(input cfg_t c);
    logic [BUS_W-1:0] w;
    w = '0;
    w[CFG_16K_BIT]   = c.save_16k;
    w[CFG_SAVE_BIT]  = c.save_en;
    w[CFG_SDRAM_BIT] = c.sdram_en;
    return w;
  endfunction

  // true when addr lies in the 2**lg byte window at base and the low
  // alignment bits selected by amask are clear
  function automatic logic win_hit(input logic [BUS_W-1:0] addr,
                                   input logic [BUS_W-1:0] base,
                                   input int lg,
                                   input logic [BUS_W-1:0] amask);
    return ((addr >> lg) == (base >> lg)) && ((addr & amask) == '0);
  endfunction

endpackage

// File: rtl/cart_addr_decode.sv
module cart_addr_decode
  import cart_pkg::*;
#(
  parameter logic [BUS_W-1:0] ROM_BASE  = 32'h1000_0000,
  parameter int               ROM_LG    = 26,
  parameter logic [BUS_W-1:0] SAVE_BASE = 32'h1D00_0000,
  parameter int               SAVE_LG   = 11,
  parameter logic [BUS_W-1:0] REG_BASE  = 32'h1E00_0000,
  parameter int               REG_NUM   = 2
) (
  input  logic             req,
  input  logic [BUS_W-1:0] addr,
  input  logic             save_en,
  output logic             rom_hit,
  output logic             save_hit,
  output logic             reg_hit,
  output logic             reg_idx,
  output logic             acc_err
);
  localparam int NWIN   = 3;
  localparam int REG_LG = $clog2(REG_NUM * 4);
  localparam logic [BUS_W-1:0] WBASE [NWIN] = '{ROM_BASE, SAVE_BASE, REG_BASE};
  localparam int               WLG   [NWIN] = '{ROM_LG, SAVE_LG, REG_LG};
  localparam logic [BUS_W-1:0] WMASK [NWIN] = '{32'h1, 32'h3, 32'h3};

  logic [NWIN-1:0] raw;

  genvar gi;
  generate
    for (gi = 0; gi < NWIN; gi++) begin : g_win
      assign raw[gi] = req && win_hit(addr, WBASE[gi], WLG[gi], WMASK[gi]);
    end
  endgenerate

  assign rom_hit  = raw[0];
  assign save_hit = raw[1] && save_en;
  assign reg_hit  = raw[2];
  assign reg_idx  = addr[2];
  assign acc_err  = req && !(rom_hit || save_hit || reg_hit);
endmodule

// File: rtl/cart_cfg_regs.sv
module cart_cfg_regs
  import cart_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_evt,
  input  logic             cfg_wr,
  input  logic             boot_wr,
  input  logic [BUS_W-1:0] wdata,
  output cfg_t             cfg,
  output logic [BUS_W-1:0] boot_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      if (cfg_wr) begin
        cfg.save_16k <= wdata[CFG_16K_BIT];
        cfg.save_en  <= wdata[CFG_SAVE_BIT];
        cfg.sdram_en <= wdata[CFG_SDRAM_BIT];
      end
      // host event overrides any concurrent write of the SDRAM enable
      if (host_evt) cfg.sdram_en <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       boot_q <= '0;
    else if (boot_wr) boot_q <= wdata;
  end
endmodule

// File: rtl/cart_reg_port.sv
module cart_reg_port
  import cart_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_hit,
  input  logic             acc_err,
  input  logic             we,
  input  logic             idx,
  input  logic [BUS_W-1:0] cfg_rd,
  input  logic [BUS_W-1:0] boot_rd,
  output logic             ack,
  output logic             err,
  output logic [BUS_W-1:0] rdata
);
  logic [BUS_W-1:0] rd_mux;
  assign rd_mux = (reg_hit && !we) ? (idx ? boot_rd : cfg_rd) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      ack   <= reg_hit || acc_err;
      err   <= acc_err;
      rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/cart_decoder.sv
module cart_decoder
  import cart_pkg::*;
#(
  parameter logic [31:0] ROM_BASE  = 32'h1000_0000,
  parameter int          ROM_LG    = 26,
  parameter logic [31:0] SAVE_BASE = 32'h1D00_0000,
  parameter int          SAVE_LG   = 11,
  parameter logic [31:0] REG_BASE  = 32'h1E00_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_evt,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic        sdram_sel,
  output logic        flash_sel,
  output logic        save_sel,
  output logic        reg_sel,
  output logic        bus_ack,
  output logic        bus_err,
  output logic [31:0] bus_rdata,
  output logic        cfg_sdram_en,
  output logic        cfg_save_serial_en,
  output logic        cfg_save_16k,
  output logic [31:0] boot_word,
  output logic        override_valid,
  output logic [1:0]  video_eff
);
  cfg_t cfg;
  logic rom_hit, save_hit, reg_idx, acc_err;
  logic cfg_wr, boot_wr;

  cart_addr_decode #(
    .ROM_BASE(ROM_BASE), .ROM_LG(ROM_LG), .SAVE_BASE(SAVE_BASE),
    .SAVE_LG(SAVE_LG), .REG_BASE(REG_BASE), .REG_NUM(2)
  ) u_dec (
    .req(bus_req), .addr(bus_addr), .save_en(cfg.save_en),
    .rom_hit(rom_hit), .save_hit(save_hit), .reg_hit(reg_sel),
    .reg_idx(reg_idx), .acc_err(acc_err)
  );

  assign sdram_sel = rom_hit && cfg.sdram_en;
  assign flash_sel = rom_hit && !cfg.sdram_en;
  assign save_sel  = save_hit;
  assign cfg_wr    = reg_sel && bus_we && !reg_idx;
  assign boot_wr   = reg_sel && bus_we && reg_idx;

  cart_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .host_evt(host_evt), .cfg_wr(cfg_wr),
    .boot_wr(boot_wr), .wdata(bus_wdata), .cfg(cfg), .boot_q(boot_word)
  );

  cart_reg_port u_port (
    .clk(clk), .rst_n(rst_n), .reg_hit(reg_sel), .acc_err(acc_err),
    .we(bus_we), .idx(reg_idx), .cfg_rd(cfg_word(cfg)), .boot_rd(boot_word),
    .ack(bus_ack), .err(bus_err), .rdata(bus_rdata)
  );

  assign cfg_sdram_en       = cfg.sdram_en;
  assign cfg_save_serial_en = cfg.save_en;
  assign cfg_save_16k       = cfg.save_16k;
  assign override_valid     = boot_code_ok(boot_word[BOOT_CODE_W-1:0]);
  assign video_eff          = eff_video(boot_word);
endmodule

// File: rtl/cart_decoder_chk.sv
module cart_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_evt,
  input logic        cfg_wr,
  input logic        acc_err,
  input logic [31:0] bus_wdata,
  input logic        sdram_sel,
  input logic        flash_sel,
  input logic        save_sel,
  input logic        reg_sel,
  input logic        bus_ack,
  input logic        bus_err,
  input logic [31:0] bus_rdata,
  input logic        cfg_sdram_en,
  input logic        cfg_save_serial_en,
  input logic        cfg_save_16k,
  input logic        override_valid,
  input logic [1:0]  video_eff
);
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sdram_sel, flash_sel, save_sel, reg_sel}));

  p_err_no_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> !(sdram_sel || flash_sel || save_sel || reg_sel));

  p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> bus_ack && bus_err && bus_rdata == 32'h0);

  p_reg_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |=> bus_ack && !bus_err);

  p_flash_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flash_sel |-> !cfg_sdram_en);

  p_save_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    save_sel |-> cfg_save_serial_en);

  p_evt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_evt |=> !cfg_sdram_en);

  p_evt_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_evt && !cfg_wr) |=> $stable(cfg_save_serial_en) && $stable(cfg_save_16k));

  p_wr_effect_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !host_evt) |=> cfg_sdram_en == $past(bus_wdata[1]));

  p_video_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !override_valid |-> video_eff == 2'd3);
endmodule

bind cart_decoder cart_decoder_chk u_chk (.*);

// File: tb/sim_cart_decoder.sv
module sim_cart_decoder;
  logic clk = 1'b0, rst_n = 1'b0, host_evt = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic sdram_sel, flash_sel, save_sel, reg_sel, bus_ack, bus_err;
  logic [31:0] bus_rdata, boot_word;
  logic cfg_sdram_en, cfg_save_serial_en, cfg_save_16k, override_valid;
  logic [1:0] video_eff;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cart_decoder u0 (.*);

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [5:0]  flags;  // {sdram, flash, save, reg, ack, err}
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h1000_0000, 32'h0,         6'b010000, 32'h0},          // R2 flash
    '{1'b1, 32'h1E00_0000, 32'hFFFF_FFFF, 6'b000110, 32'h0},          // R4 write
    '{1'b0, 32'h1E00_0000, 32'h0,         6'b000110, 32'h0000_001A},  // R5
    '{1'b0, 32'h13FF_FFFE, 32'h0,         6'b100000, 32'h0},          // R2 R11
    '{1'b0, 32'h1000_0001, 32'h0,         6'b000011, 32'h0},          // R10
    '{1'b0, 32'h1D00_07FC, 32'h0,         6'b001000, 32'h0},          // R3
    '{1'b0, 32'h1D00_0800, 32'h0,         6'b000011, 32'h0},          // R3 edge
    '{1'b0, 32'h1D00_0002, 32'h0,         6'b000011, 32'h0},          // R3 align
    '{1'b1, 32'h1E00_0004, 32'hDEAD_BEE5, 6'b000110, 32'h0},          // R7
    '{1'b0, 32'h1E00_0004, 32'h0,         6'b000110, 32'hDEAD_BEE5},  // R7
    '{1'b0, 32'h1E00_0008, 32'h0,         6'b000011, 32'h0},          // R10
    '{1'b1, 32'h1E00_0002, 32'h0,         6'b000011, 32'h0},          // R10
    '{1'b0, 32'h1E00_0000, 32'h0,         6'b000110, 32'h0000_001A},  // R10 kept
    '{1'b1, 32'h1E00_0000, 32'h0,         6'b000110, 32'h0},          // R11
    '{1'b0, 32'h1000_0000, 32'h0,         6'b010000, 32'h0},          // R11 flash
    '{1'b0, 32'h1D00_0000, 32'h0,         6'b000011, 32'h0},          // R3 gated
    '{1'b0, 32'h0000_0000, 32'h0,         6'b000011, 32'h0},          // R10
    '{1'b0, 32'h1400_0000, 32'h0,         6'b000011, 32'h0}           // R2 edge
  };

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                        input logic evt, output logic [3:0] sel,
                        output logic ack, output logic err, output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; host_evt = evt;
    #1;
    sel = {sdram_sel, flash_sel, save_sel, reg_sel};
    @(posedge clk); #1;
    ack = bus_ack; err = bus_err; rd = bus_rdata;
    bus_req = 1'b0; bus_we = 1'b0; host_evt = 1'b0;
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [3:0] s; logic k, e; logic [31:0] r;
    logic [5:0] got;

    // R1: reset state
    #5;
    check({cfg_save_16k, cfg_save_serial_en, cfg_sdram_en} == 3'b0, "R1 cfg", {29'h0, cfg_save_16k, cfg_save_serial_en, cfg_sdram_en}, 0);
    check(boot_word == 0, "R1 boot", boot_word, 0);
    check(!override_valid && video_eff == 2'd3, "R1 video", {30'h0, video_eff}, 3);
    check({sdram_sel, flash_sel, save_sel, reg_sel, bus_ack, bus_err} == 6'b0, "R1 strobes",
          {26'h0, sdram_sel, flash_sel, save_sel, reg_sel, bus_ack, bus_err}, 0);
    @(negedge clk); rst_n = 1'b1;

    // vector table: R2 R3 R4 R5 R7 R10 R11
    for (int i = 0; i < NV; i++) begin
      access(VEC[i].we, VEC[i].addr, VEC[i].wd, 1'b0, s, k, e, r);
      got = {s, k, e};
      check(got == VEC[i].flags, $sformatf("R2/R3/R4/R10 vec%0d flags", i), {26'h0, got}, {26'h0, VEC[i].flags});
      check(r == VEC[i].rd, $sformatf("R4/R5/R7 vec%0d rdata", i), r, VEC[i].rd);
      check($onehot0(s), "R12 strobes", {28'h0, s}, 0);
    end

    // R8 R9: sweep all boot codes with video field NTSC (1)
    for (int c = 0; c < 16; c++) begin
      logic ev; logic [1:0] evid;
      access(1'b1, 32'h1E00_0004, {26'h155, 2'b01, 4'(c)}, 1'b0, s, k, e, r);
      ev = (c >= 1) && (c <= 7);
      evid = ev ? 2'd1 : 2'd3;
      check(override_valid == ev, $sformatf("R8 code %0d", c), {31'h0, override_valid}, {31'h0, ev});
      check(video_eff == evid, $sformatf("R9 code %0d", c), {30'h0, video_eff}, {30'h0, evid});
    end
    check(boot_word == {26'h155, 2'b01, 4'hF}, "R7 boot_word", boot_word, {26'h155, 2'b01, 4'hF});

    // R6: host event alone keeps save settings
    access(1'b1, 32'h1E00_0000, 32'h0000_001A, 1'b0, s, k, e, r);
    @(negedge clk); host_evt = 1'b1;
    @(posedge clk); #1; host_evt = 1'b0;
    check(!cfg_sdram_en && cfg_save_serial_en && cfg_save_16k, "R6 evt alone",
          {29'h0, cfg_save_16k, cfg_save_serial_en, cfg_sdram_en}, 32'h6);
    access(1'b0, 32'h1E00_0000, 32'h0, 1'b0, s, k, e, r);
    check(r == 32'h18, "R6 readback", r, 32'h18);
    access(1'b0, 32'h1000_0000, 32'h0, 1'b0, s, k, e, r);
    check(s == 4'b0100, "R6/R2 flash after evt", {28'h0, s}, 32'h4);

    // R6: event concurrent with a configuration write
    access(1'b1, 32'h1E00_0000, 32'h0000_0012, 1'b1, s, k, e, r);
    access(1'b0, 32'h1E00_0000, 32'h0, 1'b0, s, k, e, r);
    check(r == 32'h10, "R6 evt+write", r, 32'h10);

    // R1: reset mid-run clears everything
    access(1'b1, 32'h1E00_0004, 32'h1234_5678, 1'b0, s, k, e, r);
    @(negedge clk); rst_n = 1'b0; #1;
    check(boot_word == 0 && !cfg_save_16k, "R1 re-reset", boot_word, 0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    finish_run();
  end
endmodule